// File: doc/BRIEF.md
# Stop Mode Power Controller

This block puts a processor core and its peripherals into a low-power stop state and brings them back out. Software writes one control byte. The byte holds four things: a stop request, the choice of how the wake line ends stop, what the port pins do while stopped, and which clock feeds stage 9 of the timebase divider. A stop request takes the run enable away from the core and peripherals. It also parks the port pins, either floating or holding their last value.

While stopped, the block watches a wake line. That line first passes through a parameterised synchroniser. The wake line can end stop in one of two ways, chosen by the control byte: on a new low-to-high transition, or whenever the line is high. Once stop is released, a warm-up counter is loaded from a count input and runs down. When it expires, the run enable returns, the ports go back to normal drive in that same cycle, and a one-cycle warm-up-done interrupt is raised. The oscillators, the clock gear and the divider are outside this block. Only the stage-9 source select is produced.

Top module: `stop_power_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 8'h08, `run_en` is 1, `port_hiz`, `port_hold`, `port_in_zero` and `warm_done_irq` are 0, and `div9_src_lowfreq` is 0.
- R2: `rd_data[7:4]` returns the stored control fields: bit 7 stop, bit 6 release mode, bit 5 port hold, bit 4 divider source. `rd_data[3]` always reads 1 and `rd_data[2:0]` always read 0.
- R3: A write with `wr_data[7]`=1 while `run_en` is 1 drops `run_en` from the next cycle on. A write with `wr_data[7]`=0 changes only the fields and keeps the block running.
- R4: With release mode 0 (bit 6 = 0), stop ends only on a new low-to-high transition of the synchronised wake line (`SYNC_STAGES` flops, default 2). A wake line that is already high when stop is entered and stays high does not end stop.
- R5: With release mode 1 (bit 6 = 1), stop ends in the first cycle in which the synchronised wake line is high, including a line that was already high at entry.
- R6: While `run_en` is 0 and bit 5 is 0, `port_hiz` and `port_in_zero` are 1 and `port_hold` is 0. While `run_en` is 0 and bit 5 is 1, `port_hold` is 1 and `port_hiz` and `port_in_zero` are 0.
- R7: `div9_src_lowfreq` equals control bit 4: 0 selects gear clock / 2, 1 selects low-frequency clock / 4.
- R8: The stop bit clears in the cycle that stop is released, so `rd_data[7]` reads 0 during warm-up and after wake-up.
- R9: After release, `run_en` stays 0 for max(`warm_count`, 1) cycles, counted with the `warm_count` value sampled at release, and then returns to 1.
- R10: `warm_done_irq` is a one-cycle pulse that is high exactly in the first cycle in which `run_en` is 1 again.
- R11: The port controls return to 0 in the same cycle that `run_en` returns to 1.
- R12: Writes while `run_en` is 0 are ignored: `rd_data` and all outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control byte readback |
| wake_in | input | 1 | Asynchronous stop-release line |
| warm_count | input | WUC_W | Warm-up length in cycles, sampled at release |
| run_en | output | 1 | Run enable to core and peripherals |
| port_hiz | output | 1 | Port outputs floating |
| port_hold | output | 1 | Port outputs held |
| port_in_zero | output | 1 | Port internal inputs forced to 0 |
| div9_src_lowfreq | output | 1 | Divider stage-9 source select |
| warm_done_irq | output | 1 | Warm-up done pulse |

## Verification
Stop episodes are driven with random release modes, port settings, divider selects and warm-up counts, including 0 and 1. The wake line toggles at random, so the two release modes are tried against the same patterns. A wake line held high across stop entry separates edge sensing from level sensing. A short wake pulse separates edges that occur inside stop from edges that occur before it. Writes issued during stop and warm-up show whether the register is locked while the core is not running.

// File: rtl/stpc_pkg.sv
package stpc_pkg;
   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_STOP = 2'd1,
      PH_WARM = 2'd2
   } phase_t;

   typedef struct packed {
      logic stop;
      logic lvl_rel;
      logic hold_out;
      logic div_lf;
   } ctl_t;

   localparam int unsigned CTL_BITS = $bits(ctl_t);
   localparam logic [3:0] RD_LOW_NIBBLE = 4'b1000;
endpackage

// File: rtl/stpc_ctl_reg.sv
module stpc_ctl_reg
   import stpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ok,
   input  logic [7:0] wr_data,
   input  logic       clr_stop,
   output ctl_t       ctl,
   output logic [7:0] rd_data
);
   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ok) begin
         ctl_q <= ctl_t'(wr_data[7:8-CTL_BITS]);
      end else if (clr_stop) begin
         ctl_q.stop <= 1'b0;
      end
   end

   assign ctl     = ctl_q;
   assign rd_data = {ctl_q, RD_LOW_NIBBLE};
endmodule

// File: rtl/stpc_wake_det.sv
module stpc_wake_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_in,
   output logic wake_lvl,
   output logic wake_rise
);
   logic wake_s;
   logic wake_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign wake_s = wake_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= (chain << 1) | SYNC_STAGES'(wake_in);
         end
         assign wake_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_prev <= 1'b0;
      else        wake_prev <= wake_s;
   end

   assign wake_lvl  = wake_s;
   assign wake_rise = wake_s & ~wake_prev;
endmodule

// File: rtl/stpc_warmup.sv
module stpc_warmup #(
   parameter int unsigned WUC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WUC_W-1:0] load_val,
   input  logic             active,
   output logic             expire
);
   localparam logic [WUC_W-1:0] ONE = WUC_W'(1);
   logic [WUC_W-1:0] cnt;

   assign expire = active && (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (active && !expire) cnt <= cnt - ONE;
   end
endmodule

// File: rtl/stop_power_ctrl.sv
module stop_power_ctrl
   import stpc_pkg::*;
#(
   parameter int unsigned WUC_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic             wake_in,
   input  logic [WUC_W-1:0] warm_count,
   output logic             run_en,
   output logic             port_hiz,
   output logic             port_hold,
   output logic             port_in_zero,
   output logic             div9_src_lowfreq,
   output logic             warm_done_irq
);
   initial begin
      if (WUC_W < 2 || WUC_W > 32) $fatal(1, "WUC_W out of range");
      if (SYNC_STAGES > 4)         $fatal(1, "SYNC_STAGES out of range");
   end

   phase_t phase;
   ctl_t   ctl;
   logic   wake_lvl, wake_rise;
   logic   release_now, expire, wr_ok, enter_stop, irq_q;

   assign wr_ok       = wr_en && (phase == PH_RUN);
   assign enter_stop  = wr_ok && wr_data[7];
   assign release_now = (phase == PH_STOP) && (ctl.lvl_rel ? wake_lvl : wake_rise);

   stpc_ctl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ok    (wr_ok),
      .wr_data  (wr_data),
      .clr_stop (release_now),
      .ctl      (ctl),
      .rd_data  (rd_data)
   );

   stpc_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake_in   (wake_in),
      .wake_lvl  (wake_lvl),
      .wake_rise (wake_rise)
   );

   stpc_warmup #(.WUC_W(WUC_W)) u_wuc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (release_now),
      .load_val (warm_count),
      .active   (phase == PH_WARM),
      .expire   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_RUN;
         irq_q <= 1'b0;
      end else begin
         irq_q <= (phase == PH_WARM) && expire;
         unique case (phase)
            PH_RUN:  if (enter_stop)  phase <= PH_STOP;
            PH_STOP: if (release_now) phase <= PH_WARM;
            PH_WARM: if (expire)      phase <= PH_RUN;
            default:                  phase <= PH_RUN;
         endcase
      end
   end

   logic parked;
   assign parked           = (phase != PH_RUN);
   assign run_en           = ~parked;
   assign port_hiz         = parked & ~ctl.hold_out;
   assign port_in_zero     = parked & ~ctl.hold_out;
   assign port_hold        = parked &  ctl.hold_out;
   assign div9_src_lowfreq = ctl.div_lf;
   assign warm_done_irq    = irq_q;
endmodule

// File: rtl/stop_power_ctrl_chk.sv
module stop_power_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       run_en,
   input logic       port_hiz,
   input logic       port_hold,
   input logic       port_in_zero,
   input logic       warm_done_irq
);
   AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[3:0] == 4'b1000); // R2
   AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && wr_en && wr_data[7]) |=> !run_en); // R3
   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_hiz && port_hold) && (port_in_zero == port_hiz)); // R6
   AST_STOPBIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> !rd_data[7]); // R8
   AST_IRQ_AT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      warm_done_irq |-> (run_en && !$past(run_en))); // R10
   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      warm_done_irq |=> !warm_done_irq); // R10
   AST_PORTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> !(port_hiz || port_hold || port_in_zero)); // R11
   AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && $past(!run_en)) |-> $stable(rd_data[6:4])); // R12
endmodule

bind stop_power_ctrl stop_power_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .run_en        (run_en),
   .port_hiz      (port_hiz),
   .port_hold     (port_hold),
   .port_in_zero  (port_in_zero),
   .warm_done_irq (warm_done_irq)
);

// File: tb/stop_power_ctrl_tb.sv
module stop_power_ctrl_tb;
   localparam int unsigned WUC_W = 8;
   localparam int unsigned SYNC  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic wake_in = 1'b0;
   logic [WUC_W-1:0] warm_count = '0;
   logic [7:0] rd_data;
   logic run_en, port_hiz, port_hold, port_in_zero, div9_src_lowfreq, warm_done_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stop_power_ctrl #(.WUC_W(WUC_W), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .wake_in(wake_in), .warm_count(warm_count), .run_en(run_en), .port_hiz(port_hiz),
      .port_hold(port_hold), .port_in_zero(port_in_zero),
      .div9_src_lowfreq(div9_src_lowfreq), .warm_done_irq(warm_done_irq)
   );

   // reference model: ph 0 run, 1 stop, 2 warm; ctl = {stop, lvl, hold, div}
   int unsigned m_ph = 0;
   logic [3:0] m_ctl = '0;
   logic [SYNC-1:0] m_sync = '0;
   logic m_prev = 1'b0;
   int unsigned m_cnt = 0;
   logic m_irq = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_ctl = '0; m_sync = '0; m_prev = 1'b0; m_cnt = 0; m_irq = 1'b0;
      end else begin
         logic s;
         logic rise;
         s = m_sync[SYNC-1];
         rise = s & ~m_prev;
         m_irq = (m_ph == 2) && (m_cnt <= 1);
         case (m_ph)
            0: if (wr_en) begin
                  m_ctl = wr_data[7:4];
                  if (wr_data[7]) m_ph = 1;
               end
            1: if (m_ctl[2] ? s : rise) begin
                  m_ph = 2; m_cnt = warm_count; m_ctl[3] = 1'b0;
               end
            default: if (m_cnt <= 1) m_ph = 0; else m_cnt = m_cnt - 1;
         endcase
         m_prev = s;
         m_sync = {m_sync[SYNC-2:0], wake_in};
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      logic parked;
      parked = (m_ph != 0);
      chk(rd_data == {m_ctl, 4'b1000}, "R2 rd_data", rd_data, {m_ctl, 4'b1000});
      chk(run_en == !parked, "R9 run_en", run_en, !parked);
      chk(port_hiz == (parked && !m_ctl[1]), "R6 port_hiz", port_hiz, parked && !m_ctl[1]);
      chk(port_in_zero == (parked && !m_ctl[1]), "R6 port_in_zero", port_in_zero, parked && !m_ctl[1]);
      chk(port_hold == (parked && m_ctl[1]), "R6 port_hold", port_hold, parked && m_ctl[1]);
      chk(div9_src_lowfreq == m_ctl[0], "R7 div9_src_lowfreq", div9_src_lowfreq, m_ctl[0]);
      chk(warm_done_irq == m_irq, "R10 warm_done_irq", warm_done_irq, m_irq);
   endtask

   // advance one cycle: compare at negedge, then drive next inputs
   task automatic step(input logic we, input logic [7:0] wd, input logic wk);
      @(negedge clk);
      cmp_model();
      wr_en = we; wr_data = wd; wake_in = wk;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, wake_in);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      int unsigned cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
         end
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(rd_data == 8'h08, "R1 rd_data", rd_data, 8'h08);
      chk(run_en && !port_hiz && !port_hold && !port_in_zero && !warm_done_irq && !div9_src_lowfreq,
          "R1 outputs", {run_en, port_hiz, port_hold, port_in_zero, warm_done_irq}, 5'b10000);

      // R3 / R7: field write without stop keeps running
      step(1'b1, 8'h70, 1'b0);
      step(1'b0, 8'h00, 1'b0);
      chk(run_en && rd_data == 8'h78, "R3 no-stop write", rd_data, 8'h78);
      chk(div9_src_lowfreq == 1'b1, "R7 div select", div9_src_lowfreq, 1);

      // R4: edge mode, wake high at entry must not release
      step(1'b0, 8'h00, 1'b1);
      idle(4);
      step(1'b1, 8'h80, 1'b1);
      step(1'b0, 8'h00, 1'b1);
      chk(!run_en, "R3 stop entry", run_en, 0);
      idle(10);
      chk(!run_en && rd_data[7], "R4 held-high ignored", run_en, 0);
      chk(port_hiz && port_in_zero && !port_hold, "R6 float in stop", {port_hiz, port_hold}, 2'b10);
      // R12: write while stopped ignored
      step(1'b1, 8'h70, 1'b1);
      step(1'b0, 8'h00, 1'b1);
      chk(rd_data == 8'h88 && !div9_src_lowfreq, "R12 write locked", rd_data, 8'h88);
      // new rising edge releases; warm_count 3
      warm_count = 8'd3;
      step(1'b0, 8'h00, 1'b0);
      idle(3);
      step(1'b0, 8'h00, 1'b1);
      idle(3);
      chk(!run_en && rd_data[7] == 1'b0, "R8 stop bit cleared in warm-up", rd_data, 8'h08);
      idle(3);
      chk(run_en && !port_hiz, "R11 awake", run_en, 1);
      chk(rd_data[7] == 1'b0, "R8 readback after wake", rd_data[7], 0);

      // R5: level mode with wake already high releases
      step(1'b1, 8'hE0, 1'b1);
      warm_count = 8'd0;
      idle(8);
      chk(run_en && rd_data == 8'h68, "R5 level release", rd_data, 8'h68);

      // random episodes
      for (int ep = 0; ep < 300; ep++) begin
         logic [7:0] ctl;
         ctl = {1'b1, 3'($urandom_range(0, 7)), 4'h0};
         warm_count = WUC_W'($urandom_range(0, 9));
         idle($urandom_range(0, 3));
         step(1'b1, ctl, wake_in);
         for (int c = 0; c < 40; c++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8)       step(1'b1, 8'($urandom), wake_in);
            else if (r < 30) step(1'b0, 8'h00, ~wake_in);
            else             step(1'b0, 8'h00, wake_in);
            if (c == 20) warm_count = WUC_W'($urandom_range(0, 9));
         end
         if (!run_en) begin
            step(1'b0, 8'h00, 1'b0);
            idle(4);
            step(1'b0, 8'h00, 1'b1);
            idle(SYNC + 14);
         end
      end
      idle(2);
      finish_run();
   end
endmodule